// File: doc/BRIEF.md
# Comparison-Clock Reference Divider with Lock Detector

This block turns the crystal reference clock into the comparison-rate timing of a frequency synthesizer. A 4-bit ratio code selects one of sixteen division ratios from a fixed table. Half of the table is the powers of two from 2 to 256. The other half is 3, 5 and then 5 doubled step by step up to 320. Once per divided period the block emits a one-reference-clock comparison strobe. It also drives a comparison clock. For even ratios that clock has a 50% duty cycle. For the odd ratios 3 and 5 it equals the strobe.

Beside the divider sits a lock detector. The phase detector itself is outside the block. It supplies a level, `in_window`, that says whether the current phase error is inside the lock window. That level is sampled once per comparison strobe. The lock flag rises only after 64 good comparisons in a row. One bad comparison or one change of ratio drops it.

A new ratio code is never applied in the middle of a period. It is adopted at the end of the period that is running, so every divided period is whole.

Top module: `refdiv_lock`

## Requirements
- R1: Codes 0 to 7 give periods of 2, 4, 8, 16, 32, 64, 128 and 256 reference cycles, in that order of code.
- R2: Codes 8 to 15 give periods of 3, 5, 10, 20, 40, 80, 160 and 320 reference cycles, in that order of code.
- R3: `cmp_tick` is high for exactly one reference cycle per period, on the last cycle of the period.
- R4: For an even ratio N, `cmp_clk` is high for the first N/2 cycles of each period and low for the remaining N/2.
- R5: For an odd ratio (3 or 5), `cmp_clk` equals `cmp_tick`.
- R6: A change of `ratio_code` takes effect only at a period boundary. The code is sampled on the cycle on which `cmp_tick` is high, and the next period uses the ratio it selects.
- R7: `lock` rises on the clock edge that consumes the 64th consecutive strobe cycle with `in_window` high, and never sooner.
- R8: A strobe cycle with `in_window` low clears the run count, and `lock` is low on the following cycle.
- R9: When a boundary adopts a ratio different from the one in use, that comparison is not counted, the run count restarts from zero, and `lock` is low on the following cycle.
- R10: While `rst_n` is low, `lock` and `cmp_tick` are low and the active ratio is 2. The first period after reset is 2 cycles long.
- R11: `in_window` is ignored on cycles without a strobe. Once the run count reaches 64 it saturates, and `lock` stays high while every strobe stays good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (crystal) clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| ratio_code | input | 4 | Division ratio select code |
| in_window | input | 1 | Phase error within lock window, sampled on strobe cycles |
| cmp_tick | output | 1 | One-cycle comparison strobe at the end of each period |
| cmp_clk | output | 1 | Comparison clock (50% duty for even ratios, the strobe for odd ones) |
| lock | output | 1 | Lock flag |

## Verification
The divider boundary and the lock evaluation fall in the same cycle, because a ratio change is adopted on exactly the strobe cycle where `in_window` is judged. The bench provokes this by changing `ratio_code` while the detector is locked and holding `in_window` high. It then expects the restart to win over the good sample, with `lock` dropping one cycle later. The bench also changes the code in the middle of long periods and drives `in_window` low only on non-strobe cycles. A behavioural model, stepped every clock, judges all three outputs cycle by cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int RD_CODE_W = 4;
    localparam int RD_CNT_W  = 9;

    typedef struct packed {
        logic [RD_CNT_W-1:0] cnt;
        logic [RD_CNT_W-1:0] ratio;
    } div_state_t;

    // Ratio table: low half binary powers, high half 3, 5 and 5*2^k.
    function automatic logic [RD_CNT_W-1:0] ratio_of(input logic [RD_CODE_W-1:0] code);
        logic [RD_CNT_W-1:0] r;
        if (code[RD_CODE_W-1] == 1'b0) begin
            r = RD_CNT_W'(2) << code[RD_CODE_W-2:0];
        end else if (code[RD_CODE_W-2:0] == '0) begin
            r = RD_CNT_W'(3);
        end else begin
            r = RD_CNT_W'(5) << (code[RD_CODE_W-2:0] - 1'b1);
        end
        return r;
    endfunction
endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RD_CODE_W-1:0] ratio_code,
    output logic                 tick,
    output logic                 clk_out,
    output logic                 restart
);
    div_state_t          div_d, div_q;
    logic [RD_CNT_W-1:0] sel_ratio;
    logic [RD_CNT_W-1:0] half_ratio;

    always_comb begin
        sel_ratio  = ratio_of(ratio_code);
        half_ratio = div_q.ratio >> 1;
        tick       = (div_q.cnt == (div_q.ratio - RD_CNT_W'(1)));
        restart    = tick && (sel_ratio != div_q.ratio);
        clk_out    = div_q.ratio[0] ? tick : (div_q.cnt < half_ratio);
        div_d      = div_q;
        if (tick) begin
            div_d.cnt   = '0;
            div_d.ratio = sel_ratio;
        end else begin
            div_d.cnt   = div_q.cnt + RD_CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt   <= '0;
            div_q.ratio <= RD_CNT_W'(2);
        end else begin
            div_q <= div_d;
        end
    end

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt < div_q.ratio);
    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    p_ratio_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(div_q.ratio));
    p_odd_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.ratio[0] |-> (clk_out == tick));
endmodule

// File: rtl/refdiv_lockdet.sv
module refdiv_lockdet #(
    parameter int RUN_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic in_window,
    output logic lock
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
    } lock_state_t;

    lock_state_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (tick) begin
            if (restart || !in_window) begin
                lk_d.run  = '0;
                lk_d.lock = 1'b0;
            end else begin
                if (lk_q.run != RUN_MAX) begin
                    lk_d.run = lk_q.run + RUN_W'(1);
                end
                lk_d.lock = (lk_d.run == RUN_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign lock = lk_q.lock;

    p_lock_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_q.lock) |-> (lk_q.run == RUN_MAX));
    p_bad_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !in_window) |=> !lk_q.lock);
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!lk_q.lock && lk_q.run == '0));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lk_q));
endmodule

// File: rtl/refdiv_lock.sv
module refdiv_lock
    import refdiv_pkg::*;
#(
    parameter int RUN_LEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RD_CODE_W-1:0] ratio_code,
    input  logic                 in_window,
    output logic                 cmp_tick,
    output logic                 cmp_clk,
    output logic                 lock
);
    logic restart;

    refdiv_counter u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .tick       (cmp_tick),
        .clk_out    (cmp_clk),
        .restart    (restart)
    );

    refdiv_lockdet #(.RUN_LEN(RUN_LEN)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cmp_tick),
        .restart   (restart),
        .in_window (in_window),
        .lock      (lock)
    );

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!lock && !cmp_tick));
endmodule

// File: tb/sim_refdiv_lock.sv
module sim_refdiv_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd0;
    logic       win = 1'b0;
    logic       cmp_tick, cmp_clk, lock;

    refdiv_lock u0 (
        .clk(clk), .rst_n(rst_n), .ratio_code(code), .in_window(win),
        .cmp_tick(cmp_tick), .cmp_clk(cmp_clk), .lock(lock)
    );

    always #2 clk = ~clk;

    int    m_cnt = 0, m_ratio = 2, m_run = 0, m_lock = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    run_cmp = 1'b0, done = 1'b0;
    string tag = "R10";

    function automatic int lut(int c);
        if (c < 8) return 2 ** (c + 1);
        if (c == 8) return 3;
        return 5 * (2 ** (c - 9));
    endfunction

    task automatic chk(string rq, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // Behavioural reference, stepped every reference clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ratio = 2; m_run = 0; m_lock = 0;
        end else if (m_cnt == m_ratio - 1) begin
            int nr;
            nr = lut(int'(code));
            if (nr != m_ratio || !win) begin
                m_run = 0; m_lock = 0;
            end else begin
                if (m_run < 64) m_run++;
                m_lock = (m_run >= 64) ? 1 : 0;
            end
            m_ratio = nr;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (run_cmp) begin
            int et, ec;
            et = (m_cnt == m_ratio - 1) ? 1 : 0;
            ec = (m_ratio % 2 == 0) ? ((m_cnt < m_ratio / 2) ? 1 : 0) : et;
            chk(tag, int'(cmp_tick), et);
            chk(tag, int'(cmp_clk), ec);
            chk(tag, int'(lock), m_lock);
        end
    end

    task automatic step(int n, int mode);
        // mode 0: win low, 1: win high, 2: random, 3: high only on strobe cycles
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (mode)
                0: win = 1'b0;
                1: win = 1'b1;
                2: win = 1'($urandom % 2);
                default: win = cmp_tick;
            endcase
        end
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!cmp_tick) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        @(posedge clk);
        @(negedge clk);
        run_cmp = 1'b1;
        chk("R10", int'(lock), 0);
        chk("R10", int'(cmp_tick), 0);
        step(2, 0);
        rst_n = 1'b1;
        // first period after reset is 2 cycles: tick on second cycle
        @(negedge clk);
        chk("R10", int'(cmp_tick), 1);

        tag = "R1 R3 R4";
        for (int c = 0; c < 8; c++) begin
            code = 4'(c);
            step(3 * lut(c) + 3, 2);
        end

        tag = "R2 R5";
        for (int c = 8; c < 16; c++) begin
            code = 4'(c);
            step(3 * lut(c) + 3, 2);
        end

        tag = "R6";
        code = 4'd7;
        step(600, 2);
        wait_tick();
        step(100, 2);
        code = 4'd9;
        step(40, 2);
        code = 4'd2;
        step(300, 2);

        tag = "R7";
        code = 4'd0;
        step(10, 0);
        step(120, 1);
        chk("R7", int'(lock), 0);
        step(20, 1);
        chk("R7", int'(lock), 1);

        tag = "R11";
        step(60, 3);
        chk("R11", int'(lock), 1);

        tag = "R8";
        wait_tick();
        win = 1'b0;
        @(negedge clk);
        win = 1'b1;
        chk("R8", int'(lock), 0);
        step(140, 1);

        tag = "R9";
        chk("R9", int'(lock), 1);
        code = 4'd8;
        step(4, 1);
        chk("R9", int'(lock), 0);
        step(200, 1);
        chk("R9", int'(lock), 1);

        run_cmp = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule